// File: doc/BRIEF.md
# L3 Three-Wire Control Bus Master

This block is the host end of a three-wire control bus (clock, data and mode lines) that programs an audio codec. Each transaction starts with one address byte. The upper six bits of that byte select the device and the lower two bits select the register type. The address byte is followed by zero or more data bytes. The data bytes are written out from the host or read in from the device, and the data line is released to input for reads.

A request carries the address byte, a direction flag and a byte count. The master accepts a request only when it is idle. It then raises all three lines, clocks the address byte out with the mode line low, and moves every data byte with the mode line high. Every data byte after the first is preceded by a clock-low halt pulse. At the end the master drops all lines to a low, undriven state. Write bytes are pulled from the host with a one-cycle take strobe. Read bytes are returned with a one-cycle valid strobe. The clock-low, clock-high, setup, hold and halt times are parameters counted in system clock cycles, each at least one cycle.

Top module: `l3_bus_master`

## Requirements
- R1: While no transaction runs, `busy` is 0 and all bus outputs and both drive enables are 0.
- R2: A request taken while idle raises `busy`. In the next cycle it drives clock, mode and data high with both enables on, for exactly one cycle.
- R3: Every byte is 8 bits and is sent least significant bit first, so bit 0 is presented at the first rising bus clock. While the control enable is on, the data line changes only in cycles where the bus clock is low.
- R4: For each bit, the bus clock is low for `T_LOW` cycles and then high for `T_HIGH` cycles. Received bits are sampled in the last low cycle.
- R5: For the address byte, the mode line is 0 and the data line is driven. The clock first goes low for `T_SETUP` cycles before bit 0. After bit 7 the clock stays high for `T_HOLD` cycles.
- R6: Data bytes carry mode 1. The first data byte follows the address hold at once, with `T_SETUP` clock-high cycles. Each later byte begins with a `T_HALT`-cycle clock-low pulse. The number of busy cycles is therefore 1 + (1+N)(T_SETUP+8(T_LOW+T_HIGH)+T_HOLD) + max(N-1,0)·T_HALT.
- R7: On a write, `wr_take` pulses once per data byte, and `wr_data` is consumed at the clock edge that ends that pulse cycle.
- R8: On a read, the data enable is 0 for the whole data phase. After each 8th bit, `rd_valid` pulses with the assembled byte on `rd_data`. `wr_take` never pulses.
- R9: `done` pulses for exactly one cycle, in the first cycle after `busy` falls.
- R10: A request made while `busy` is 1 is ignored. The running transfer is unchanged, and no second transfer follows.
- R11: A byte count of 0 produces an address-only transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_addr | input | 8 | Address byte: device in 7:2, register type in 1:0 |
| req_len | input | LEN_W | Number of data bytes |
| wr_data | input | 8 | Next write byte, consumed when wr_take is high |
| wr_take | output | 1 | Write byte consumed this cycle |
| rd_data | output | 8 | Received byte, valid with rd_valid |
| rd_valid | output | 1 | One-cycle strobe per received byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| l3_clk_o | output | 1 | Bus clock level |
| l3_mode_o | output | 1 | Bus mode level |
| l3_ctl_oe | output | 1 | Drive enable for clock and mode lines |
| l3_data_o | output | 1 | Bus data output level |
| l3_data_oe | output | 1 | Drive enable for the data line |
| l3_data_i | input | 1 | Bus data input level |

## Verification
A wrong bit counter adds or drops a rising bus clock within the byte it affects, so the captured byte value and the byte count are wrong before `done` arrives. A timer or phase error moves the length of a single low run, and the total busy length, by whole cycles. The bench measures both on every transaction. A wrong direction or phase flag shows up in the mode level recorded at each byte, or as the data enable being on during a read bit, at the very rising edge concerned.

// File: rtl/l3m_pkg.sv
package l3m_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SETUP,
        ST_BLOW,
        ST_BHIGH,
        ST_HOLD,
        ST_HALT
    } l3m_state_e;

    typedef enum logic [1:0] {
        SH_KEEP,
        SH_LOAD,
        SH_OUT,
        SH_IN
    } l3m_shop_e;

endpackage

// File: rtl/l3m_delay_timer.sv
module l3m_delay_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/l3m_shifter.sv
module l3m_shifter
    import l3m_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  l3m_shop_e    op,
    input  logic [W-1:0] load_val,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        case (op)
            SH_LOAD: q_d = load_val;
            SH_OUT:  q_d = {1'b0, q_q[W-1:1]};
            SH_IN:   q_d = {din, q_q[W-1:1]};
            default: q_d = q_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/l3_bus_master.sv
module l3_bus_master
    import l3m_pkg::*;
#(
    parameter int T_LOW   = 4,
    parameter int T_HIGH  = 4,
    parameter int T_SETUP = 2,
    parameter int T_HOLD  = 2,
    parameter int T_HALT  = 4,
    parameter int LEN_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [7:0]       req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             l3_clk_o,
    output logic             l3_mode_o,
    output logic             l3_ctl_oe,
    output logic             l3_data_o,
    output logic             l3_data_oe,
    input  logic             l3_data_i
);
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int M1     = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
    localparam int M2     = (T_SETUP > T_HOLD) ? T_SETUP : T_HOLD;
    localparam int M3     = (M1 > M2) ? M1 : M2;
    localparam int T_MAX  = (M3 > T_HALT) ? M3 : T_HALT;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    typedef struct packed {
        l3m_state_e       state;
        logic [BIT_W-1:0] bit_cnt;
        logic [LEN_W-1:0] left;
        logic             in_data;
        logic             is_wr;
        logic             clk;
        logic             mode;
        logic             dat;
        logic             ctl_oe;
        logic             dat_oe;
        logic             busy;
        logic             done;
        logic             rd_valid;
    } regs_t;

    regs_t            d, q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    l3m_shop_e        sh_op;
    logic [7:0]       sh_val;
    logic [7:0]       sh_q;
    logic             take_c;

    l3m_delay_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    l3m_shifter #(.W(BYTE_W)) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (sh_op),
        .load_val (sh_val),
        .din      (l3_data_i),
        .q        (sh_q)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.rd_valid = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        sh_op      = SH_KEEP;
        sh_val     = req_addr;
        take_c     = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state   = ST_START;
                    d.is_wr   = req_write;
                    d.left    = req_len;
                    d.in_data = 1'b0;
                    d.clk     = 1'b1;
                    d.mode    = 1'b1;
                    d.dat     = 1'b1;
                    d.ctl_oe  = 1'b1;
                    d.dat_oe  = 1'b1;
                    d.busy    = 1'b1;
                    sh_op     = SH_LOAD;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(1);
                end
            end
            ST_START: begin
                if (tmr_exp) begin
                    d.state  = ST_SETUP;
                    d.clk    = 1'b0;
                    d.mode   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_SETUP);
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    d.state   = ST_BLOW;
                    d.clk     = 1'b0;
                    d.bit_cnt = '0;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(T_LOW);
                    if (!q.in_data) begin
                        d.dat = sh_q[0];
                    end else if (q.is_wr) begin
                        take_c = 1'b1;
                        sh_op  = SH_LOAD;
                        sh_val = wr_data;
                        d.dat  = wr_data[0];
                    end
                end
            end
            ST_BLOW: begin
                if (tmr_exp) begin
                    d.state  = ST_BHIGH;
                    d.clk    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_HIGH);
                    if (q.in_data && !q.is_wr) sh_op = SH_IN;
                end
            end
            ST_BHIGH: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (q.bit_cnt == BIT_W'(BYTE_W - 1)) begin
                        d.state    = ST_HOLD;
                        tmr_val    = CNT_W'(T_HOLD);
                        d.rd_valid = q.in_data && !q.is_wr;
                    end else begin
                        d.state   = ST_BLOW;
                        d.clk     = 1'b0;
                        d.bit_cnt = q.bit_cnt + BIT_W'(1);
                        tmr_val   = CNT_W'(T_LOW);
                        if (!q.in_data || q.is_wr) begin
                            sh_op = SH_OUT;
                            d.dat = sh_q[1];
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    if (q.left == '0) begin
                        d.state   = ST_IDLE;
                        d.clk     = 1'b0;
                        d.mode    = 1'b0;
                        d.dat     = 1'b0;
                        d.ctl_oe  = 1'b0;
                        d.dat_oe  = 1'b0;
                        d.busy    = 1'b0;
                        d.done    = 1'b1;
                        d.in_data = 1'b0;
                    end else begin
                        d.left    = q.left - LEN_W'(1);
                        d.mode    = 1'b1;
                        d.in_data = 1'b1;
                        d.dat_oe  = q.is_wr;
                        tmr_load  = 1'b1;
                        if (q.in_data) begin
                            d.state = ST_HALT;
                            d.clk   = 1'b0;
                            tmr_val = CNT_W'(T_HALT);
                        end else begin
                            d.state = ST_SETUP;
                            d.clk   = 1'b1;
                            tmr_val = CNT_W'(T_SETUP);
                        end
                    end
                end
            end
            ST_HALT: begin
                if (tmr_exp) begin
                    d.state  = ST_SETUP;
                    d.clk    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_SETUP);
                end
            end
            default: d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_take    = take_c;
    assign rd_data    = sh_q;
    assign rd_valid   = q.rd_valid;
    assign busy       = q.busy;
    assign done       = q.done;
    assign l3_clk_o   = q.clk;
    assign l3_mode_o  = q.mode;
    assign l3_ctl_oe  = q.ctl_oe;
    assign l3_data_o  = q.dat;
    assign l3_data_oe = q.dat_oe;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!l3_ctl_oe && !l3_data_oe && !l3_clk_o && !l3_mode_o));

    assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l3_ctl_oe && $past(l3_ctl_oe) && l3_clk_o && $past(l3_clk_o)) |-> $stable(l3_data_o));

    assert_addr_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !l3_mode_o) |-> l3_data_oe);

    assert_take_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> !wr_take);

    assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.in_data && !q.is_wr) |-> !l3_data_oe);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    assert_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.is_wr));
endmodule

// File: tb/l3_bus_master_tb_top.sv
module l3_bus_master_tb_top;
    localparam int TL = 2, TH = 1, TS = 2, TD = 1, TA = 3, LW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, req_valid, req_write;
    logic [7:0]    req_addr, wr_data, rd_data, rd_now;
    logic [LW-1:0] req_len;
    logic          wr_take, rd_valid, busy, done;
    logic          l3_clk_o, l3_mode_o, l3_ctl_oe, l3_data_o, l3_data_oe, l3_data_i;

    int checks = 0, errors = 0, cyc = 0;
    int busy_cnt, low_cnt, take_cnt, done_cnt, rd_cnt, viol, oe_viol, lr_err;
    int cap_n, bitn, lowrun, widx;
    bit take_pend, halt_seen, cur_wr;
    logic prev_clk = 1'b0, prev_oe = 1'b0, prev_dat = 1'b0;
    logic [7:0] bsh, seed;
    logic [7:0] cap [16];
    logic       cap_mode [16];
    logic [7:0] got_rd [16];

    function automatic logic [7:0] wpat(input int k, input logic [7:0] s);
        return 8'(k * 77) ^ s ^ 8'h3C;
    endfunction

    function automatic logic [7:0] rpat(input int k, input logic [7:0] s);
        return 8'(k * 39 + 145) ^ s;
    endfunction

    assign wr_data   = wpat(widx, seed);
    assign rd_now    = rpat(cap_n - 1, seed);
    assign l3_data_i = rd_now[bitn[2:0]];

    l3_bus_master #(.T_LOW(TL), .T_HIGH(TH), .T_SETUP(TS), .T_HOLD(TD),
                    .T_HALT(TA), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
        .l3_clk_o(l3_clk_o), .l3_mode_o(l3_mode_o), .l3_ctl_oe(l3_ctl_oe),
        .l3_data_o(l3_data_o), .l3_data_oe(l3_data_oe), .l3_data_i(l3_data_i)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // bus monitor and device model, sampled between active edges
    always @(negedge clk) begin : mon
        int e;
        if (take_pend) widx++;
        take_pend = wr_take;
        if (busy) busy_cnt++;
        if (busy && !l3_clk_o) low_cnt++;
        if (wr_take) take_cnt++;
        if (done) done_cnt++;
        if (rd_valid) begin
            if (rd_cnt < 16) got_rd[rd_cnt] = rd_data;
            rd_cnt++;
        end
        if (l3_ctl_oe && prev_oe && l3_clk_o && prev_clk && (l3_data_o != prev_dat)) viol++;
        if (l3_ctl_oe && !l3_clk_o) lowrun++;
        if (l3_ctl_oe && prev_oe && l3_clk_o && !prev_clk) begin
            if (bitn == 0 && cap_n >= 2 && !halt_seen) begin
                halt_seen = 1'b1;
                if (lowrun != TA) lr_err++;
            end else begin
                e = (bitn == 0 && cap_n == 0) ? TS + TL : TL;
                if (lowrun != e) lr_err++;
                if (!cur_wr && l3_mode_o && l3_data_oe) oe_viol++;
                bsh = {l3_data_o, bsh[7:1]};
                bitn++;
                if (bitn == 8) begin
                    if (cap_n < 16) begin
                        cap[cap_n]      = bsh;
                        cap_mode[cap_n] = l3_mode_o;
                    end
                    cap_n++;
                    bitn      = 0;
                    halt_seen = 1'b0;
                end
            end
            lowrun = 0;
        end
        prev_clk = l3_clk_o;
        prev_oe  = l3_ctl_oe;
        prev_dat = l3_data_o;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string rq);
        chk(!busy && !l3_clk_o && !l3_mode_o && !l3_data_o && !l3_ctl_oe && !l3_data_oe,
            rq, "idle bus", {busy, l3_clk_o, l3_mode_o, l3_data_o, l3_ctl_oe, l3_data_oe}, 0);
    endtask

    task automatic run_txn(input bit wr, input logic [7:0] addr, input int len, input bit inject);
        int exp_busy;
        @(negedge clk);
        busy_cnt = 0; low_cnt = 0; take_cnt = 0; done_cnt = 0; rd_cnt = 0;
        viol = 0; oe_viol = 0; lr_err = 0; cap_n = 0; bitn = 0; lowrun = 0;
        widx = 0; take_pend = 1'b0; halt_seen = 1'b0; cur_wr = wr;
        seed = addr ^ 8'(len * 17);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = LW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk(l3_clk_o && l3_mode_o && l3_data_o && l3_ctl_oe && l3_data_oe && busy,
            "R2", "start lines high", {l3_clk_o, l3_mode_o, l3_data_o, l3_ctl_oe, l3_data_oe, busy}, 63);
        if (inject) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1; req_write = !wr; req_addr = ~addr; req_len = LW'(len + 1);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        exp_busy = 1 + (1 + len) * (TS + 8 * (TL + TH) + TD) + ((len > 1) ? (len - 1) * TA : 0);
        chk(busy_cnt == exp_busy, "R6", "busy cycles", busy_cnt, exp_busy);
        chk(low_cnt == TS + (1 + len) * 8 * TL + ((len > 1) ? (len - 1) * TA : 0),
            "R4", "clock low cycles", low_cnt, TS + (1 + len) * 8 * TL + ((len > 1) ? (len - 1) * TA : 0));
        chk(lr_err == 0, "R4", "low run length errors", lr_err, 0);
        chk(viol == 0, "R3", "data change with clock high", viol, 0);
        chk(cap_n == 1 + len, (len == 0) ? "R11" : "R3", "bytes on bus", cap_n, 1 + len);
        chk(cap[0] == addr, "R5", "address byte", int'(cap[0]), int'(addr));
        chk(cap_mode[0] == 1'b0, "R5", "address mode level", int'(cap_mode[0]), 0);
        for (int k = 1; k <= len && k < cap_n; k++)
            chk(cap_mode[k] == 1'b1, "R6", "data mode level", int'(cap_mode[k]), 1);
        if (wr) begin
            chk(take_cnt == len, "R7", "take strobes", take_cnt, len);
            for (int k = 1; k <= len && k < cap_n; k++)
                chk(cap[k] == wpat(k - 1, seed), "R7", "written byte",
                    int'(cap[k]), int'(wpat(k - 1, seed)));
        end else begin
            chk(take_cnt == 0, "R8", "take strobes on read", take_cnt, 0);
            chk(oe_viol == 0, "R8", "data driven during read", oe_viol, 0);
            chk(rd_cnt == len, "R8", "read strobes", rd_cnt, len);
            for (int k = 0; k < len && k < rd_cnt; k++)
                chk(got_rd[k] == rpat(k, seed), "R8", "read byte",
                    int'(got_rd[k]), int'(rpat(k, seed)));
        end
        chk(done_cnt == 1, inject ? "R10" : "R9", "done pulses", done_cnt, 1);
        chk_idle(inject ? "R10" : "R1");
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
        seed = '0; widx = 0; cap_n = 0; bitn = 0;
        repeat (4) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_idle("R1");
        chk(!done && !rd_valid && !wr_take, "R9", "no strobes after reset",
            {done, rd_valid, wr_take}, 0);
        for (int wr = 0; wr < 2; wr++)
            for (int len = 0; len <= 7; len++)
                run_txn(wr[0], {6'(len * 9 + wr * 21 + 5), 2'(len)}, len, 1'b0);
        run_txn(1'b1, 8'h5A, 2, 1'b1);
        run_txn(1'b0, 8'hC3, 3, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule